// File: doc/BRIEF.md
# Dual-Clock Scanline Fetch Controller

This block keeps two alternating line caches, one for even display lines and one for odd display lines, filled with pixel words fetched from the frame buffer. On the logic-clock side each cache acts as an independent memory user on the shared memory-user bus. The cache raises a request line. A bus master selects it and reads a two-word request descriptor from the top of the user's address space. The master then writes the fetched line into the cache one dword at a time, starting at cache word 0.

On the pixel-clock side a display driver sends three kinds of single-cycle trigger: frame restart, fill even and fill odd. It reads pixels through the second port of each cache RAM with a one-cycle registered read. The drain side never checks whether a line is valid; it reads at the time the display needs the data. Every trigger reaches the logic clock through a synchronizer stage inside this block. The pixel clock is half the logic clock.

Each cache holds its own frame-buffer line address. A frame restart sets the even cache to the frame start and the odd cache to the frame start plus one line stride. Each completed fill moves that cache's address on by two strides, because the two caches take alternate lines.

Top module: `scan_fetch_ctrl`

## Requirements
- R1: After reset both request lines are low, and the bus read data is zero.
- R2: A fill trigger for one cache raises only that cache's request line within a few logic-clock cycles. The line stays high until the cache is selected and is low from the cycle after selection.
- R3: While a cache is selected, a bus read of user address 0xFFC returns the command in bits 31:24 as 0x00 (fetch from frame buffer into the user) and the line length in dwords in bits 23:0.
- R4: While a cache is selected, a bus read of user address 0xFFD returns its current line address. After a frame restart the even cache holds FB_START and the odd cache holds FB_START + LINE_STRIDE.
- R5: When a cache's select drops, its line address advances by 2 x LINE_STRIDE.
- R6: A frame-restart trigger puts both line addresses back to their start values, whatever fills came before.
- R7: A bus write while a cache is selected, with user address below the cache depth, stores the data at cache word = address. The pixel read port of that cache returns the word one pixel-clock cycle after the address is presented.
- R8: A cache that is not selected ignores bus writes, and its contents are unchanged. When no cache is selected the bus read data is zero.
- R9: While selected, a bus read of any user address other than 0xFFC and 0xFFD returns zero.
- R10: If select is dropped before the whole line is written, the fill counts as complete. The line address still advances, and words that were not written keep their earlier contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Logic clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously in each domain |
| pclk | input | 1 | Pixel clock (logic clock divided by two) |
| px_frame_start | input | 1 | Pixel-domain pulse: restart both line addresses |
| px_fill_even | input | 1 | Pixel-domain pulse: request a fill of the even cache |
| px_fill_odd | input | 1 | Pixel-domain pulse: request a fill of the odd cache |
| px_even_addr | input | CACHE_AW | Even cache pixel-side word address |
| px_even_data | output | DATA_W | Even cache pixel-side read data (registered) |
| px_odd_addr | input | CACHE_AW | Odd cache pixel-side word address |
| px_odd_data | output | DATA_W | Odd cache pixel-side read data (registered) |
| mu_strobe | input | 1 | Bus access strobe |
| mu_write | input | 1 | 1 = master writes to user, 0 = master reads from user |
| mu_addr | input | BUS_ADDR_W | User dword address |
| mu_wdata | input | DATA_W | Data from master |
| mu_rdata | output | DATA_W | Data from the selected user (zero if none) |
| even_irq | output | 1 | Even cache service request |
| even_sel | input | 1 | Even cache selected by master |
| odd_irq | output | 1 | Odd cache service request |
| odd_sel | input | 1 | Odd cache selected by master |

## Verification
Every fill writes its own data pattern, so a stale line read back on the pixel port shows up as a mismatch with the newest pattern. The even and odd fills are interleaved across two frames. The descriptor address is checked on each fill, which separates the per-cache start offset, the two-stride advance and the restart to the frame start. An early deselect checks that the address still advances and that the unwritten tail keeps the old line. Writes made with the other cache selected, or with no cache selected, check that only the selected cache is written.

// File: rtl/scan_pkg.sv
package scan_pkg;
  typedef enum logic [1:0] {
    TRG_FRAME = 2'd0,
    TRG_EVEN  = 2'd1,
    TRG_ODD   = 2'd2
  } trig_e;

  localparam int NUM_TRIG  = 3;
  localparam int NUM_CACHE = 2;
  localparam logic [7:0] CMD_FB_READ = 8'h00;
  localparam int LEN_W = 24;
endpackage

// File: rtl/scan_rst_sync.sv
module scan_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [1:0] stage_q;
  logic [1:0] stage_d;

  always_comb begin
    stage_d = {stage_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) stage_q <= '0;
    else         stage_q <= stage_d;
  end

  assign srst_n = stage_q[1];
endmodule

// File: rtl/scan_trig_sync.sv
module scan_trig_sync #(
  parameter int N = 3
) (
  input  logic         pclk,
  input  logic         prst_n,
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] trig_px,
  output logic [N-1:0] trig_pulse
);
  for (genvar i = 0; i < N; i++) begin : g_ch
    logic       tog_q, tog_d;
    logic [2:0] sync_q, sync_d;

    always_comb begin
      tog_d = tog_q ^ trig_px[i];
    end

    always_ff @(posedge pclk or negedge prst_n) begin
      if (!prst_n) tog_q <= 1'b0;
      else         tog_q <= tog_d;
    end

    always_comb begin
      sync_d = {sync_q[1:0], tog_q};
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sync_q <= '0;
      else        sync_q <= sync_d;
    end

    assign trig_pulse[i] = sync_q[1] ^ sync_q[2];

    AST_SYNC_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      trig_pulse[i] |=> !trig_pulse[i]); // R2
  end
endmodule

// File: rtl/scan_dpram.sv
module scan_dpram #(
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 8,
  parameter int LANE_W  = 16
) (
  input  logic              wclk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              rclk,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int LANES = DATA_W / LANE_W;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];
    logic [LANE_W-1:0] rd_q;

    always_ff @(posedge wclk) begin
      if (we) mem[waddr] <= wdata[l*LANE_W +: LANE_W];
    end

    always_ff @(posedge rclk) begin
      rd_q <= mem[raddr];
    end

    assign rdata[l*LANE_W +: LANE_W] = rd_q;
  end
endmodule

// File: rtl/scan_mu_port.sv
module scan_mu_port
  import scan_pkg::*;
#(
  parameter int          BUS_ADDR_W = 12,
  parameter int          DATA_W     = 32,
  parameter int          CACHE_AW   = 8,
  parameter int          LINE_WORDS = 160,
  parameter logic [31:0] BASE_START = 32'h0,
  parameter logic [31:0] BASE_STEP  = 32'd320
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  fill_i,
  input  logic                  frame_i,
  input  logic                  sel_i,
  input  logic                  strobe_i,
  input  logic                  write_i,
  input  logic [BUS_ADDR_W-1:0] addr_i,
  output logic                  irq_o,
  output logic [DATA_W-1:0]     rdata_o,
  output logic                  ram_we_o,
  output logic [CACHE_AW-1:0]   ram_addr_o
);
  localparam logic [BUS_ADDR_W-1:0] A_CMD  = BUS_ADDR_W'((1 << BUS_ADDR_W) - 4);
  localparam logic [BUS_ADDR_W-1:0] A_BASE = BUS_ADDR_W'((1 << BUS_ADDR_W) - 3);
  localparam logic [LEN_W-1:0]      LEN    = LEN_W'(LINE_WORDS);

  logic              irq_q, irq_d;
  logic              sel_q, sel_d;
  logic [DATA_W-1:0] base_q, base_d;
  logic              rd_en;

  always_comb begin
    irq_d = sel_i ? 1'b0 : (irq_q | fill_i);
    sel_d = sel_i;
    if (frame_i)              base_d = DATA_W'(BASE_START);
    else if (sel_q && !sel_i) base_d = base_q + DATA_W'(BASE_STEP);
    else                      base_d = base_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q  <= 1'b0;
      sel_q  <= 1'b0;
      base_q <= DATA_W'(BASE_START);
    end else begin
      irq_q  <= irq_d;
      sel_q  <= sel_d;
      base_q <= base_d;
    end
  end

  assign rd_en = sel_i && strobe_i && !write_i;

  always_comb begin
    rdata_o = '0;
    if (rd_en) begin
      if (addr_i == A_CMD)       rdata_o = DATA_W'({CMD_FB_READ, LEN});
      else if (addr_i == A_BASE) rdata_o = base_q;
    end
  end

  assign irq_o      = irq_q;
  assign ram_we_o   = sel_i && strobe_i && write_i &&
                      (addr_i[BUS_ADDR_W-1:CACHE_AW] == '0);
  assign ram_addr_o = addr_i[CACHE_AW-1:0];

  AST_IRQ_DROP_ON_SEL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sel_i) |=> !irq_o); // R2
  AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && !sel_i) |=> irq_o); // R2
  AST_BASE_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(sel_i) && !frame_i) |=> (base_q == $past(base_q) + DATA_W'(BASE_STEP))); // R5
  AST_BASE_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    frame_i |=> (base_q == DATA_W'(BASE_START))); // R6
endmodule

// File: rtl/scan_fetch_ctrl.sv
module scan_fetch_ctrl
  import scan_pkg::*;
#(
  parameter int          BUS_ADDR_W  = 12,
  parameter int          DATA_W      = 32,
  parameter int          CACHE_AW    = 8,
  parameter int          LINE_WORDS  = 160,
  parameter logic [31:0] FB_START    = 32'h0,
  parameter logic [31:0] LINE_STRIDE = 32'd160
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  pclk,
  input  logic                  px_frame_start,
  input  logic                  px_fill_even,
  input  logic                  px_fill_odd,
  input  logic [CACHE_AW-1:0]   px_even_addr,
  output logic [DATA_W-1:0]     px_even_data,
  input  logic [CACHE_AW-1:0]   px_odd_addr,
  output logic [DATA_W-1:0]     px_odd_data,
  input  logic                  mu_strobe,
  input  logic                  mu_write,
  input  logic [BUS_ADDR_W-1:0] mu_addr,
  input  logic [DATA_W-1:0]     mu_wdata,
  output logic [DATA_W-1:0]     mu_rdata,
  output logic                  even_irq,
  input  logic                  even_sel,
  output logic                  odd_irq,
  input  logic                  odd_sel
);
  localparam logic [31:0] STEP = LINE_STRIDE << 1;

  logic                 srst_n, prst_n;
  logic [NUM_TRIG-1:0]  trig_px, trig_pulse;
  logic [NUM_CACHE-1:0] sel, irq, fill, we;
  logic [CACHE_AW-1:0]  waddr  [NUM_CACHE];
  logic [CACHE_AW-1:0]  px_addr[NUM_CACHE];
  logic [DATA_W-1:0]    px_data[NUM_CACHE];
  logic [DATA_W-1:0]    rd_part[NUM_CACHE];

  scan_rst_sync u_rst_clk (.clk(clk),  .arst_n(rst_n), .srst_n(srst_n));
  scan_rst_sync u_rst_pix (.clk(pclk), .arst_n(rst_n), .srst_n(prst_n));

  always_comb begin
    trig_px                = '0;
    trig_px[int'(TRG_FRAME)] = px_frame_start;
    trig_px[int'(TRG_EVEN)]  = px_fill_even;
    trig_px[int'(TRG_ODD)]   = px_fill_odd;
  end

  scan_trig_sync #(.N(NUM_TRIG)) u_sync (
    .pclk(pclk), .prst_n(prst_n), .clk(clk), .rst_n(srst_n),
    .trig_px(trig_px), .trig_pulse(trig_pulse)
  );

  assign fill[0]    = trig_pulse[int'(TRG_EVEN)];
  assign fill[1]    = trig_pulse[int'(TRG_ODD)];
  assign sel        = {odd_sel, even_sel};
  assign px_addr[0] = px_even_addr;
  assign px_addr[1] = px_odd_addr;

  for (genvar g = 0; g < NUM_CACHE; g++) begin : g_cache
    scan_mu_port #(
      .BUS_ADDR_W(BUS_ADDR_W), .DATA_W(DATA_W), .CACHE_AW(CACHE_AW),
      .LINE_WORDS(LINE_WORDS),
      .BASE_START(FB_START + (g * LINE_STRIDE)),
      .BASE_STEP(STEP)
    ) u_port (
      .clk(clk), .rst_n(srst_n),
      .fill_i(fill[g]), .frame_i(trig_pulse[int'(TRG_FRAME)]),
      .sel_i(sel[g]), .strobe_i(mu_strobe), .write_i(mu_write), .addr_i(mu_addr),
      .irq_o(irq[g]), .rdata_o(rd_part[g]),
      .ram_we_o(we[g]), .ram_addr_o(waddr[g])
    );

    scan_dpram #(.DATA_W(DATA_W), .ADDR_W(CACHE_AW)) u_ram (
      .wclk(clk), .we(we[g]), .waddr(waddr[g]), .wdata(mu_wdata),
      .rclk(pclk), .raddr(px_addr[g]), .rdata(px_data[g])
    );
  end

  assign mu_rdata     = rd_part[0] | rd_part[1];
  assign even_irq     = irq[0];
  assign odd_irq      = irq[1];
  assign px_even_data = px_data[0];
  assign px_odd_data  = px_data[1];

  AST_IDLE_BUS_QUIET: assert property (@(posedge clk) disable iff (!srst_n)
    !(even_sel || odd_sel) |-> (mu_rdata == '0)); // R8
endmodule

// File: tb/scan_fetch_ctrl_tb_top.sv
module scan_fetch_ctrl_tb_top;
  localparam logic [31:0] FBS = 32'h1000;
  localparam logic [31:0] STR = 32'h40;
  localparam int          LW  = 16;

  logic clk, pclk, rst_n;
  logic px_frame_start, px_fill_even, px_fill_odd;
  logic [7:0]  px_even_addr, px_odd_addr;
  logic [31:0] px_even_data, px_odd_data;
  logic        mu_strobe, mu_write;
  logic [11:0] mu_addr;
  logic [31:0] mu_wdata, mu_rdata;
  logic        even_irq, odd_irq, even_sel, odd_sel;

  scan_fetch_ctrl #(.LINE_WORDS(LW), .FB_START(FBS), .LINE_STRIDE(STR)) dut_i (
    .clk(clk), .rst_n(rst_n), .pclk(pclk),
    .px_frame_start(px_frame_start), .px_fill_even(px_fill_even), .px_fill_odd(px_fill_odd),
    .px_even_addr(px_even_addr), .px_even_data(px_even_data),
    .px_odd_addr(px_odd_addr), .px_odd_data(px_odd_data),
    .mu_strobe(mu_strobe), .mu_write(mu_write), .mu_addr(mu_addr),
    .mu_wdata(mu_wdata), .mu_rdata(mu_rdata),
    .even_irq(even_irq), .even_sel(even_sel), .odd_irq(odd_irq), .odd_sel(odd_sel)
  );

  initial begin clk = 0;  forever #10 clk = ~clk; end
  initial begin pclk = 0; forever #20 pclk = ~pclk; end

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  typedef struct { bit c; logic [31:0] d; string tag; } exp_t;
  exp_t sb_q[$];
  logic [31:0] model [2][LW];
  bit pend, pend_c;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // monitor: compare pixel-port data against the scoreboard
  always @(negedge pclk) begin
    if (pend) begin
      exp_t e;
      e = sb_q.pop_front();
      chk(e.tag, e.c ? px_odd_data : px_even_data, e.d);
    end
  end

  task automatic px_pulse(input int which);
    @(negedge pclk);
    case (which)
      0: px_frame_start = 1;
      1: px_fill_even   = 1;
      default: px_fill_odd = 1;
    endcase
    @(negedge pclk);
    px_frame_start = 0; px_fill_even = 0; px_fill_odd = 0;
  endtask

  task automatic wait_irq(input bit c, input string tag);
    bit seen = 0;
    for (int k = 0; k < 20 && !seen; k++) begin
      @(negedge clk);
      seen = c ? odd_irq : even_irq;
    end
    chk(tag, {31'd0, seen}, 32'd1);
    chk(tag, {31'd0, c ? even_irq : odd_irq}, 32'd0);
  endtask

  task automatic serve(input bit c, input logic [31:0] exp_base, input string btag,
                       input int n, input logic [31:0] seed);
    wait_irq(c, "R2");
    @(negedge clk);
    if (c) odd_sel = 1; else even_sel = 1;
    mu_strobe = 1; mu_write = 0; mu_addr = 12'hFFC;
    #2 chk("R3", mu_rdata, {8'h00, 24'(LW)});
    @(negedge clk);
    chk("R2", {31'd0, c ? odd_irq : even_irq}, 32'd0);
    mu_addr = 12'hFFD;
    #2 chk(btag, mu_rdata, exp_base);
    @(negedge clk);
    mu_addr = 12'h005;
    #2 chk("R9", mu_rdata, 32'd0);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      mu_write = 1; mu_addr = 12'(i); mu_wdata = seed + i * 32'h01010101;
      model[c][i] = mu_wdata;
    end
    @(negedge clk);
    mu_strobe = 0; mu_write = 0; even_sel = 0; odd_sel = 0;
    repeat (3) @(negedge clk);
  endtask

  task automatic bus_write_unsel(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    mu_strobe = 1; mu_write = 1; mu_addr = a; mu_wdata = d;
    @(negedge clk);
    mu_strobe = 0; mu_write = 0;
  endtask

  task automatic px_check(input bit c, input string tag);
    for (int i = 0; i < LW; i++) begin
      exp_t e;
      @(negedge pclk);
      if (c) px_odd_addr = 8'(i); else px_even_addr = 8'(i);
      e.c = c; e.d = model[c][i]; e.tag = tag;
      sb_q.push_back(e);
      pend <= 1;
    end
    @(negedge pclk);
    pend <= 0;
    @(negedge pclk);
  endtask

  initial begin
    rst_n = 0; pend = 0; pend_c = 0;
    px_frame_start = 0; px_fill_even = 0; px_fill_odd = 0;
    px_even_addr = 0; px_odd_addr = 0;
    mu_strobe = 0; mu_write = 0; mu_addr = 0; mu_wdata = 0;
    even_sel = 0; odd_sel = 0;
    repeat (10) @(negedge clk);
    rst_n = 1;
    repeat (6) @(negedge clk);
    chk("R1", {30'd0, odd_irq, even_irq}, 32'd0);
    mu_strobe = 1; mu_addr = 12'hFFC;
    #2 chk("R1", mu_rdata, 32'd0);
    mu_strobe = 0;

    // frame 1
    px_pulse(0);
    px_pulse(1);
    serve(0, FBS, "R4", LW, 32'hA0000000);
    px_pulse(2);
    serve(1, FBS + STR, "R4", LW, 32'hB0000000);
    px_check(0, "R7");
    px_check(1, "R7");

    // second pair: advance, unselected writes, early drop
    px_pulse(1);
    serve(0, FBS + 2 * STR, "R5", LW, 32'hC0000000);
    bus_write_unsel(12'h000, 32'hDEADBEEF);
    bus_write_unsel(12'h001, 32'hDEADBEEF);
    px_check(0, "R8");
    px_pulse(2);
    serve(1, FBS + 3 * STR, "R5", 4, 32'hD0000000);
    px_check(0, "R8");
    px_check(1, "R10");
    px_pulse(2);
    serve(1, FBS + 5 * STR, "R10", LW, 32'hE0000000);

    // frame restart
    px_pulse(0);
    px_pulse(1);
    serve(0, FBS, "R6", LW, 32'h10000000);
    px_pulse(2);
    serve(1, FBS + STR, "R6", LW, 32'h20000000);
    px_check(1, "R7");

    @(negedge clk);
    mu_strobe = 1; mu_write = 0; mu_addr = 12'hFFD;
    #2 chk("R8", mu_rdata, 32'd0);
    mu_strobe = 0;
    repeat (4) @(negedge clk);
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule